// File: doc/BRIEF.md
# Adaptive Hold Logic Unit

This block sits in front of a variable-latency multiplier. For every operand pair it decides whether the array can finish in one clock or needs two. When two clocks are needed, it drops the enable of the multiplier's input registers for exactly one cycle. The decision counts the zero bits of one operand. For a column-bypassing array this is the multiplicand; for a row-bypassing array it is the multiplicator. A pattern with many zeros bypasses enough adder cells to finish in a single cycle.

A small wear monitor watches the timing-error pulses from the downstream error-detecting flops. It counts them over a fixed window of accepted operations. If one window holds more errors than a set limit, the monitor declares the array aged. From then on the block demands one more zero bit before it grants a single-cycle slot. The choice is sticky until reset, so the threshold never swings back and forth between windows.

Top module: `hold_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to its idle state after that edge: `load_en` = 1, the monitor is not aged, and the window and error counters are zero.
- R2: With `row_mode` = 0 the judged operand is `multiplicand`; with `row_mode` = 1 it is `multiplicator`. The other operand has no effect on `load_en`.
- R3: While not aged, an operand with more than ZTH zero bits (default 8 of 16) is judged one-cycle. An operand with ZTH or fewer zero bits is judged two-cycle.
- R4: Suppose `load_en` is 1 and the current operand is judged two-cycle. Then `load_en` is 0 after the next clock edge.
- R5: If `load_en` is 0, it is 1 after the next clock edge, whatever the operand is. A stall never lasts longer than one cycle.
- R6: An error window spans WIN_OPS cycles with `op_accept` = 1 (default 256), counted from reset. Every cycle with `err_pulse` = 1 inside the window counts as one error, including the window's last cycle. Both counts restart from zero after each window.
- R7: A window that closes with more than ERR_LIMIT errors (default 4) makes the block aged from the next cycle on. While aged, an operand is judged one-cycle only if it has more than ZTH+1 zero bits; with exactly ZTH+1 zero bits it is judged two-cycle.
- R8: Once aged, the block stays aged until reset, even through later windows with no errors.
- R9: A window that closes with exactly ERR_LIMIT errors does not make the block aged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_mode | input | 1 | 0: judge multiplicand (column bypass), 1: judge multiplicator (row bypass) |
| multiplicand | input | OP_W | Multiplicand operand |
| multiplicator | input | OP_W | Multiplicator operand |
| err_pulse | input | 1 | One-cycle timing-error report from the result flops |
| op_accept | input | 1 | High for one cycle per operation accepted |
| load_en | output | 1 | Enable for the multiplier's input registers |

## Verification
The aged state is the hardest situation to reach from the ports. It appears only after a full window of accepted operations closes with more errors than the limit, and the monitor itself is never visible at the ports. The stimulus runs whole 256-strobe windows with chosen error counts: exactly the limit, then one error, then one over the limit, then none. After each window it probes with operands holding exactly ZTH+1 and ZTH+2 zeros. The stall or non-stall on `load_en` then reveals which threshold is active.

// File: rtl/ahl_pkg.sv
// Shared types and helpers for the adaptive hold logic unit.
// Assumes: nothing beyond IEEE 1800-2017 elaboration rules.
package ahl_pkg;

    // Which zero-count threshold is in force.
    typedef enum logic {
        JUDGE_FRESH = 1'b0,
        JUDGE_AGED  = 1'b1
    } judge_sel_e;

    // Width needed to hold a count from 0 to n inclusive.
    function automatic int count_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/zero_counter.sv
// Population count of zero bits in an operand, purely combinational.
// Assumes: W >= 1; the count width covers 0..W.
module zero_counter #(
    parameter int W  = 16,
    parameter int CW = ahl_pkg::count_width(W)
) (
    input  logic [W-1:0]  op,
    output logic [CW-1:0] zeros
);
    // Add up the inverted operand bits.
    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            zeros = zeros + {{(CW-1){1'b0}}, ~op[i]};
        end
    end
endmodule

// File: rtl/threshold_judges.sv
// Two judges that grant a one-cycle slot when the zero count beats their
// threshold (ZTH and ZTH+1). A selector picks the one in force.
// Assumes: ZTH + 1 fits in a 32-bit int.
module threshold_judges #(
    parameter int CW  = 5,
    parameter int ZTH = 8
) (
    input  logic              [CW-1:0] zeros,
    input  ahl_pkg::judge_sel_e        sel,
    output logic                       one_cycle
);
    logic [1:0] pass;

    // One comparator per judge; judge k needs more than ZTH+k zeros.
    for (genvar k = 0; k < 2; k++) begin : g_judge
        localparam int T = ZTH + k;
        assign pass[k] = (int'(zeros) > T);
    end

    // Route the selected judge's verdict to the output.
    always_comb begin
        unique case (sel)
            ahl_pkg::JUDGE_FRESH: one_cycle = pass[0];
            ahl_pkg::JUDGE_AGED:  one_cycle = pass[1];
            default:              one_cycle = pass[0];
        endcase
    end
endmodule

// File: rtl/aging_monitor.sv
// Counts error pulses across windows of accepted operations. The aged flag
// is set when a closing window holds more than ERR_LIMIT errors.
// Assumes: WIN_OPS >= 2; the flag stays set until reset.
module aging_monitor #(
    parameter int WIN_OPS   = 256,
    parameter int ERR_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_accept,
    input  logic err_pulse,
    output logic aged
);
    localparam int WW = ahl_pkg::count_width(WIN_OPS - 1);
    localparam int EW = ahl_pkg::count_width(ERR_LIMIT + 1);
    localparam logic [WW-1:0] WLAST = WW'(WIN_OPS - 1);
    localparam logic [EW-1:0] ESAT  = EW'(ERR_LIMIT + 1);

    logic [WW-1:0] win_cnt;
    logic [EW-1:0] err_cnt;
    logic [EW-1:0] err_next;
    logic          win_close;

    // Error count including this cycle's pulse, saturating one above the limit.
    always_comb begin
        err_next  = (err_pulse && (err_cnt != ESAT)) ? err_cnt + 1'b1 : err_cnt;
        win_close = op_accept && (win_cnt == WLAST);
    end

    // Advance the window, gather errors and latch the sticky aged flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
            err_cnt <= '0;
            aged    <= 1'b0;
        end else if (win_close) begin
            win_cnt <= '0;
            err_cnt <= '0;
            if (err_next == ESAT) aged <= 1'b1;
        end else begin
            if (op_accept) win_cnt <= win_cnt + 1'b1;
            err_cnt <= err_next;
        end
    end
endmodule

// File: rtl/hold_ctrl.sv
// Adaptive hold logic top. It picks the operand to judge, counts its zeros,
// applies the threshold chosen by the aging monitor, and drives the
// input-register enable through a flop that can stall for one cycle at most.
// Assumes: the operands are stable for the cycle being judged; err_pulse and
// op_accept are single-cycle strobes.
module hold_ctrl #(
    parameter int OP_W      = 16,
    parameter int ZTH       = 8,
    parameter int WIN_OPS   = 256,
    parameter int ERR_LIMIT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            row_mode,
    input  logic [OP_W-1:0] multiplicand,
    input  logic [OP_W-1:0] multiplicator,
    input  logic            err_pulse,
    input  logic            op_accept,
    output logic            load_en
);
    localparam int CW = ahl_pkg::count_width(OP_W);

    logic [OP_W-1:0]     judged_op;
    logic [CW-1:0]       zeros;
    logic                aged;
    logic                one_cycle;
    ahl_pkg::judge_sel_e sel;

    // Choose the operand that governs bypassing in this array style.
    always_comb begin
        judged_op = row_mode ? multiplicator : multiplicand;
        sel       = aged ? ahl_pkg::JUDGE_AGED : ahl_pkg::JUDGE_FRESH;
    end

    zero_counter #(.W(OP_W), .CW(CW)) u_zc (
        .op    (judged_op),
        .zeros (zeros)
    );

    threshold_judges #(.CW(CW), .ZTH(ZTH)) u_judge (
        .zeros     (zeros),
        .sel       (sel),
        .one_cycle (one_cycle)
    );

    aging_monitor #(.WIN_OPS(WIN_OPS), .ERR_LIMIT(ERR_LIMIT)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_accept (op_accept),
        .err_pulse (err_pulse),
        .aged      (aged)
    );

    // Enable flop: the next state is the verdict ORed with the inverted state.
    always_ff @(posedge clk) begin
        if (!rst_n) load_en <= 1'b1;
        else        load_en <= one_cycle | ~load_en;
    end
endmodule

// File: rtl/hold_ctrl_chk.sv
// Property checker for hold_ctrl, attached through bind.
// Assumes: it is bound to every hold_ctrl instance.
module hold_ctrl_chk #(
    parameter int OP_W = 16,
    parameter int ZTH  = 8,
    parameter int CW   = ahl_pkg::count_width(OP_W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_en,
    input logic          one_cycle,
    input logic          aged,
    input logic [CW-1:0] zeros
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (load_en && !aged));

    // R4
    two_cycle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !one_cycle) |=> !load_en);

    // R5
    stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> load_en);

    // R3
    fresh_th_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !aged |-> (one_cycle == (int'(zeros) > ZTH)));

    // R7
    aged_th_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aged |-> (one_cycle == (int'(zeros) > ZTH + 1)));

    // R8
    aged_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aged |=> aged);
endmodule

bind hold_ctrl hold_ctrl_chk #(.OP_W(OP_W), .ZTH(ZTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .one_cycle (one_cycle),
    .aged      (aged),
    .zeros     (zeros)
);

// File: tb/tb_hold_ctrl.sv
`timescale 1ns/1ps
module tb_hold_ctrl;
    localparam int OP_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            row_mode = 1'b0;
    logic [OP_W-1:0] multiplicand = '0;
    logic [OP_W-1:0] multiplicator = '0;
    logic            err_pulse = 1'b0;
    logic            op_accept = 1'b0;
    logic            load_en;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    hold_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .row_mode      (row_mode),
        .multiplicand  (multiplicand),
        .multiplicator (multiplicator),
        .err_pulse     (err_pulse),
        .op_accept     (op_accept),
        .load_en       (load_en)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: load_en=%b expected %b", req, what, got, exp);
        end
    endtask

    // R1: reset drives the enable high.
    task automatic t_reset();
        rst_n = 1'b0;
        multiplicand = 16'hFFFF;
        repeat (3) step();
        check(load_en, 1'b1, "R1", "enable during reset");
        multiplicand = '0;
        rst_n = 1'b1;
        step();
        check(load_en, 1'b1, "R1", "enable after release");
    endtask

    // R3/R4/R5: fresh threshold, boundary at 8 and 9 zeros.
    task automatic t_fresh();
        row_mode = 1'b0;
        multiplicand = 16'h00FF;            // 8 zeros: two cycles
        step();
        check(load_en, 1'b0, "R4", "8 zeros stalls");
        step();
        check(load_en, 1'b1, "R5", "stall ends after one cycle");
        multiplicand = 16'h007F;            // 9 zeros: one cycle
        step();
        check(load_en, 1'b1, "R3", "9 zeros single cycle");
        step();
        check(load_en, 1'b1, "R3", "9 zeros again");
        multiplicand = 16'hFFFF;
        step();
        check(load_en, 1'b0, "R4", "no zeros stalls");
        step();
        check(load_en, 1'b1, "R5", "forced back high with no zeros");
        multiplicand = '0;
        step();
    endtask

    // R2: the operand picked by row_mode governs the verdict.
    task automatic t_mode();
        multiplicand  = 16'hFFFF;
        multiplicator = 16'h0000;
        row_mode = 1'b1;
        step();
        check(load_en, 1'b1, "R2", "row mode judges multiplicator");
        row_mode = 1'b0;
        step();
        check(load_en, 1'b0, "R2", "column mode judges multiplicand");
        multiplicand  = 16'h0000;
        multiplicator = 16'hFFFF;
        step();
        check(load_en, 1'b1, "R2", "column mode ignores multiplicator");
        multiplicator = '0;
    endtask

    task automatic run_window(input int nerr);
        for (int i = 0; i < 256; i++) begin
            op_accept = 1'b1;
            err_pulse = (i >= 256 - nerr);  // errors land at the window's tail
            step();
        end
        op_accept = 1'b0;
        err_pulse = 1'b0;
    endtask

    // Probe one operand from a high enable, then return the enable high.
    task automatic probe(input logic [OP_W-1:0] v, input logic exp, input string req, input string what);
        multiplicand = v;
        step();
        check(load_en, exp, req, what);
        multiplicand = '0;
        step();
    endtask

    // R6/R7/R8/R9: window accounting and the switch to the strict judge.
    task automatic t_aging();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        run_window(4);
        probe(16'h007F, 1'b1, "R9", "limit errors keep fresh judge");
        run_window(1);
        probe(16'h007F, 1'b1, "R6", "errors cleared between windows");
        run_window(5);
        probe(16'h007F, 1'b0, "R7", "aged: 9 zeros stalls");
        probe(16'h003F, 1'b1, "R7", "aged: 10 zeros single cycle");
        run_window(0);
        probe(16'h007F, 1'b0, "R8", "aged persists after clean window");
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        probe(16'h007F, 1'b1, "R1", "reset clears aging");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fresh();
        t_mode();
        t_aging();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule